// File: doc/BRIEF.md
# Interrupt Source Control Unit

This block is the per-source front end of a small vectored interrupt controller with `NSRC` request lines. Line 0 is the fast interrupt and the other lines are normal interrupts. Each line passes through a two-flop synchronizer. A per-source mode then picks how the line raises a request:

- high level or low level, or
- a rising edge or a falling edge, which is held in a latch until it is cleared.

Software controls the block through a word-addressed register bus. It sets and clears enable bits with separate write-one commands. It can force or drop the latched edge of any edge-mode source. It reads raw pending state, the mask, the current source number and the levels of the two core request lines.

A fixed-priority selector stands in for a full priority controller: the lowest-numbered enabled, pending normal source wins. Reading the IRQ vector register loads that number into the current-source register and clears the latched edge of that source only. Any source marked as fast-forced is routed to the fast line instead of the normal line. Such a source is never chosen as the current source and is never auto-cleared by a vector read. Reading the fast vector register clears the latched edge of source 0.

Top module: `irq_src_ctrl`

## Requirements
- R1: Word address i (0 <= i < NSRC) is the mode register of source i. Bits [1:0] select the trigger: 0 = high level, 1 = low level, 2 = rising edge, 3 = falling edge. Bit 2 is the fast-force flag. Reads return the value written.
- R2: In a level mode, pending bit i follows the synchronized input, inverted for low level. It shows the new level no more than 6 cycles after the input changes.
- R3: A write to address 16 sets the enable bits written as 1. A write to address 17 clears the enable bits written as 1. Bits written as 0 leave their enable unchanged. Address 18 reads the enable mask.
- R4: In an edge mode, the selected edge sets a latch, and the pending bit stays 1 after the input returns to its idle level.
- R5: A write to address 20 sets, and a write to address 21 clears, the latch of every edge-mode source whose bit is 1. For level-mode sources these writes have no effect.
- R6: Address 19 reads the pending bits of all sources, enabled or not.
- R7: A read of address 22 returns the lowest-numbered source >= 1 that is enabled, pending and not fast-forced, or 0 if there is none. The read loads that value into the current-source register, which is read at address 24. If the chosen source is in an edge mode, the read clears its latch and no other latch.
- R8: A fast-forced source that is enabled and pending drives n_fiq low. It never drives n_irq, is never returned by a read of address 22, and its latch is never cleared by such a read.
- R9: A read of address 23 returns 0 and clears the latch of source 0.
- R10: n_irq is low exactly when some source >= 1 is enabled, pending and not fast-forced. n_fiq is low exactly when source 0, or a fast-forced source, is enabled and pending. Disabled sources affect neither line. Address 25 reads n_irq in bit 0 and n_fiq in bit 1.
- R11: After reset:
  - all enables, modes and fast-force flags are 0;
  - the current source is 0;
  - n_irq and n_fiq are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NSRC | Asynchronous interrupt request lines |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (data valid the next cycle) |
| bus_addr | input | AW | Word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| n_irq | output | 1 | Normal interrupt request, active low |
| n_fiq | output | 1 | Fast interrupt request, active low |

## Verification
The hardest case to reach from the ports is a vector read when several sources are pending at once. In that case the auto-clear must hit exactly one latch, while other edge latches, level sources and fast-forced sources stay untouched. The stimulus drives a fixed mix of every trigger mode plus one fast-forced edge source. Random input toggles, enable changes and software set/clear writes pile up several pending sources before each vector read. Directed sequences cover the empty read, the fast vector read and the fast-forced source.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;
  typedef enum logic [1:0] {
    TRIG_HIGH = 2'd0,
    TRIG_LOW  = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_e;

  localparam int A_ENA_SET = 16;
  localparam int A_ENA_CLR = 17;
  localparam int A_MASK    = 18;
  localparam int A_PEND    = 19;
  localparam int A_SW_SET  = 20;
  localparam int A_SW_CLR  = 21;
  localparam int A_IRQ_VEC = 22;
  localparam int A_FIQ_VEC = 23;
  localparam int A_CUR     = 24;
  localparam int A_CORE    = 25;
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
  import irq_src_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  raw_in,
  input  trig_e trig,
  input  logic  sw_set,
  input  logic  sw_clr,
  input  logic  auto_clr,
  output logic  pend
);
  logic s1, s2, prev, lat;
  logic edge_mode, edge_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      prev <= 1'b0;
    end else begin
      s1   <= raw_in;
      s2   <= s1;
      prev <= s2;
    end
  end

  assign edge_mode = trig[1];
  assign edge_hit  = edge_mode &&
                     ((trig == TRIG_RISE) ? (s2 && !prev) : (!s2 && prev));

  // a fresh edge wins over a clear in the same cycle so no event is lost
  always_ff @(posedge clk) begin
    if (rst || !edge_mode) lat <= 1'b0;
    else if (edge_hit || sw_set) lat <= 1'b1;
    else if (sw_clr || auto_clr) lat <= 1'b0;
  end

  assign pend = edge_mode ? lat : (s2 ^ (trig == TRIG_LOW));

  // R4
  edge_latch_chk: assert property (@(posedge clk) disable iff (rst)
    edge_hit |=> lat);
  // R5
  level_nolatch_chk: assert property (@(posedge clk) disable iff (rst)
    (!edge_mode && sw_set) |=> !lat);
endmodule

// File: rtl/irq_src_sel.sv
module irq_src_sel #(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          vld,
  output logic [IW-1:0] idx
);
  always_comb begin
    vld = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        vld = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_src_ctrl.sv
module irq_src_ctrl
  import irq_src_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int AW   = 5,
  parameter int DW   = 32,
  localparam int IW  = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_in,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            n_irq,
  output logic            n_fiq
);
  trig_e           trig_q [NSRC];
  logic [NSRC-1:0] ff_q, mask_q, pend;
  logic [NSRC-1:0] irq_cand, fiq_cand, cmd;
  logic [IW-1:0]   cur_q, sel_idx, midx;
  logic            sel_vld, mode_hit;
  logic            wr_ena, wr_dis, wr_set, wr_clr, rd_ivec, rd_fvec;
  logic            unused_hi;

  assign cmd       = bus_wdata[NSRC-1:0];
  assign unused_hi = ^bus_wdata;
  assign midx      = bus_addr[IW-1:0];
  assign mode_hit  = bus_addr < AW'(NSRC);
  assign wr_ena    = bus_wr && bus_addr == AW'(A_ENA_SET);
  assign wr_dis    = bus_wr && bus_addr == AW'(A_ENA_CLR);
  assign wr_set    = bus_wr && bus_addr == AW'(A_SW_SET);
  assign wr_clr    = bus_wr && bus_addr == AW'(A_SW_CLR);
  assign rd_ivec   = bus_rd && bus_addr == AW'(A_IRQ_VEC);
  assign rd_fvec   = bus_rd && bus_addr == AW'(A_FIQ_VEC);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic auto;
    assign auto = (rd_ivec && sel_vld && sel_idx == IW'(i)) ||
                  (i == 0 && rd_fvec);
    irq_src_cell u_cell (
      .clk(clk), .rst(rst), .raw_in(src_in[i]), .trig(trig_q[i]),
      .sw_set(wr_set && cmd[i]), .sw_clr(wr_clr && cmd[i]),
      .auto_clr(auto), .pend(pend[i])
    );
  end

  assign irq_cand = pend & mask_q & ~ff_q & ~NSRC'(1);
  assign fiq_cand = pend & mask_q & (ff_q | NSRC'(1));

  irq_src_sel #(.N(NSRC)) u_sel (.req(irq_cand), .vld(sel_vld), .idx(sel_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSRC; i++) trig_q[i] <= TRIG_HIGH;
      ff_q   <= '0;
      mask_q <= '0;
      cur_q  <= '0;
      n_irq  <= 1'b1;
      n_fiq  <= 1'b1;
    end else begin
      if (bus_wr && mode_hit) begin
        trig_q[midx] <= trig_e'(bus_wdata[1:0]);
        ff_q[midx]   <= bus_wdata[2];
      end
      if (wr_ena) mask_q <= mask_q | cmd;
      else if (wr_dis) mask_q <= mask_q & ~cmd;
      if (rd_ivec) cur_q <= sel_vld ? sel_idx : '0;
      n_irq <= ~|irq_cand;
      n_fiq <= ~|fiq_cand;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      bus_rdata <= '0;
      if (mode_hit) bus_rdata <= DW'({ff_q[midx], trig_q[midx]});
      else begin
        case (int'(bus_addr))
          A_MASK:    bus_rdata <= DW'(mask_q);
          A_PEND:    bus_rdata <= DW'(pend);
          A_IRQ_VEC: bus_rdata <= DW'(sel_vld ? sel_idx : '0);
          A_CUR:     bus_rdata <= DW'(cur_q);
          A_CORE:    bus_rdata <= DW'({n_fiq, n_irq});
          default:   bus_rdata <= '0;
        endcase
      end
    end
  end

  // R3
  ena_set_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ena |=> (mask_q & $past(cmd)) == $past(cmd));
  // R3
  ena_clr_chk: assert property (@(posedge clk) disable iff (rst)
    wr_dis |=> (mask_q & $past(cmd)) == '0);
  // R7
  ivec_cur_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_ivec && sel_vld) |=> cur_q != '0);
  // R8
  fiq_line_chk: assert property (@(posedge clk) disable iff (rst)
    !n_fiq |-> $past(|fiq_cand));
  // R10
  irq_line_chk: assert property (@(posedge clk) disable iff (rst)
    !n_irq |-> $past(|irq_cand));
endmodule

// File: tb/irq_src_ctrl_test.sv
module irq_src_ctrl_test;
  localparam int N = 8;
  logic clk = 0, rst = 1;
  logic [N-1:0] src_in = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic n_irq, n_fiq;
  int total = 0, bad = 0;

  logic [1:0] m_mode [N];
  logic [N-1:0] m_ff = '0, m_mask = '0, m_lat = '0;

  irq_src_ctrl uut (.clk(clk), .rst(rst), .src_in(src_in), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .n_irq(n_irq), .n_fiq(n_fiq));

  always #5 clk = ~clk;

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bw(input int a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = 5'(a); bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic br(input int a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = 5'(a);
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  function automatic logic [N-1:0] edge_bits();
    logic [N-1:0] e;
    for (int i = 0; i < N; i++) e[i] = m_mode[i][1];
    return e;
  endfunction

  function automatic logic [N-1:0] exp_pend();
    logic [N-1:0] p;
    for (int i = 0; i < N; i++)
      p[i] = m_mode[i][1] ? m_lat[i] : (src_in[i] ^ (m_mode[i] == 2'd1));
    return p;
  endfunction

  function automatic logic [N-1:0] irqc();
    return exp_pend() & m_mask & ~m_ff & ~N'(1);
  endfunction

  function automatic logic [N-1:0] fiqc();
    return exp_pend() & m_mask & (m_ff | N'(1));
  endfunction

  task automatic set_in(input logic [N-1:0] nv);
    for (int i = 0; i < N; i++) begin
      if (m_mode[i] == 2'd2 && !src_in[i] && nv[i]) m_lat[i] = 1'b1;
      if (m_mode[i] == 2'd3 && src_in[i] && !nv[i]) m_lat[i] = 1'b1;
    end
    @(negedge clk); src_in = nv;
    repeat (6) @(negedge clk);
  endtask

  task automatic ivec(input string req);
    logic [31:0] d;
    logic [N-1:0] c;
    int w;
    c = irqc(); w = 0;
    for (int i = N - 1; i >= 1; i--) if (c[i]) w = i;
    br(22, d);
    chk(req, d, 32'(w));
    if (w != 0 && m_mode[w][1]) m_lat[w] = 1'b0;
    br(24, d);
    chk("R7 current", d, 32'(w));
  endtask

  task automatic check_state(input string tag);
    logic [31:0] d;
    repeat (2) @(negedge clk);
    br(19, d); chk({tag, " R6 pend"}, d, 32'(exp_pend()));
    br(18, d); chk({tag, " R3 mask"}, d, 32'(m_mask));
    br(25, d); chk({tag, " R10 core"}, d, {30'd0, ~|fiqc(), ~|irqc()});
  endtask

  initial begin
    logic [31:0] d;
    for (int i = 0; i < N; i++) m_mode[i] = 2'd0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    chk("R11 n_irq", 32'(n_irq), 1);
    chk("R11 n_fiq", 32'(n_fiq), 1);
    br(18, d); chk("R11 mask", d, 0);
    br(24, d); chk("R11 cur", d, 0);
    br(3, d);  chk("R11 mode", d, 0);
    // R1 mode setup and readback: src5 is fast-forced rising
    m_mode[0] = 2; m_mode[1] = 0; m_mode[2] = 1; m_mode[3] = 2;
    m_mode[4] = 3; m_mode[5] = 2; m_mode[6] = 0; m_mode[7] = 3;
    m_ff[5] = 1'b1;
    for (int i = 0; i < N; i++) bw(i, {29'd0, m_ff[i], m_mode[i]});
    for (int i = 0; i < N; i++) begin
      br(i, d); chk("R1 mode readback", d, {29'd0, m_ff[i], m_mode[i]});
    end
    repeat (6) @(negedge clk);
    // R6/R10: low-level src2 pending while disabled, no request lines
    check_state("disabled");
    // R3 enable, zero bits unchanged, disable
    bw(16, 32'h0C); m_mask = 8'h0C; check_state("ena");
    bw(16, 32'h00); check_state("ena zero");
    bw(17, 32'h04); m_mask = 8'h08; check_state("dis");
    // R2 level high source
    bw(16, 32'h42); m_mask |= 8'h42;
    set_in(8'h40); check_state("R2 level hi");
    set_in(8'h00); check_state("R2 level off");
    // R4 edge latch persists
    set_in(8'h08); set_in(8'h00); check_state("R4 edge");
    // R5 sw set on level source ignored, sw clr on edge
    bw(20, 32'h02); check_state("R5 set level");
    bw(21, 32'h08); m_lat[3] = 0; check_state("R5 clr edge");
    // R9 fast vector read clears source 0
    bw(16, 32'h01); m_mask |= 8'h01;
    set_in(8'h01); check_state("R9 before");
    chk("R9 n_fiq low", 32'(n_fiq), 0);
    br(23, d); chk("R9 fvec", d, 0); m_lat[0] = 0;
    check_state("R9 after");
    set_in(8'h00);
    // R8 fast-forced source: fiq only, not chosen, not cleared
    bw(16, 32'h20); m_mask |= 8'h20;
    set_in(8'h20); check_state("R8 ff");
    ivec("R8 ivec skips ff");
    check_state("R8 still pending");
    bw(21, 32'h20); m_lat[5] = 0;
    // R7 two edge sources: lowest first, only it cleared
    bw(16, 32'h90); m_mask |= 8'h90;
    set_in(8'h88); set_in(8'h00); check_state("R7 two");
    ivec("R7 first");
    check_state("R7 after first");
    ivec("R7 second");
    ivec("R7 empty");
    check_state("R7 done");
    // random mix
    void'($urandom(32'd1234));
    for (int k = 0; k < 300; k++) begin
      int op;
      logic [31:0] r;
      op = $urandom_range(0, 5);
      r = $urandom;
      case (op)
        0, 1: set_in(r[N-1:0]);
        2: begin
          if (r[8]) begin bw(16, {24'd0, r[7:0]}); m_mask |= r[7:0]; end
          else begin bw(17, {24'd0, r[7:0]}); m_mask &= ~r[7:0]; end
        end
        3: begin bw(20, {24'd0, r[7:0]}); m_lat |= r[7:0] & edge_bits(); end
        4: begin bw(21, {24'd0, r[7:0]}); m_lat &= ~(r[7:0] & edge_bits()); end
        default: ivec("R7 random ivec");
      endcase
      check_state("rand");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule